// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Thresholds

This block is a first-in-first-out buffer of 9-bit words. Its write side and its read side run on separate clocks, which may have no fixed relation. It reports four active-low status flags. Full and almost-full belong to the write clock. Empty and almost-empty belong to the read clock. The two almost thresholds are distances from the ends of the buffer. They arrive as inputs from a separate offset-register block, and each defaults to 7 words.

The write port has a primary active-low enable and a second, dual-purpose pin. The level of that pin while reset is held selects the mode:
- **High:** the pin acts as a second, active-high write enable, which suits chaining several buffers for more depth. In this mode the almost thresholds are fixed at the default of 7.
- **Low:** the block runs in threshold-programming mode. The pin then marks load cycles, which belong to the offset block, and the offset inputs set the almost thresholds.

A read needs both active-low read enables low. It moves the next word into an output register. An active-low output enable decides whether that register is presented on the data output. When it is not presented, the output reads zero and a drive indicator is low.

Top module: `dcfifo_thresh`

## Requirements
- R1: While reset is low, both pointers return to zero and the output register clears to zero. As a result fullN and almostFullN read 1, emptyN and almostEmptyN read 0, and rdData reads 0 when outEnN is 0.
- R2: If wrEn2Ld is 1 during reset (two-enable mode), a word is written only on a wrClk edge where wrEnN is 0 and wrEn2Ld is 1. With wrEnN 0 and wrEn2Ld 0, nothing is stored.
- R3: If wrEn2Ld is 0 during reset (programming mode), wrEnN alone starts writes while wrEn2Ld is 1. A cycle with wrEnN 0 and wrEn2Ld 0 is a load cycle for the offset block and stores nothing in the buffer.
- R4: A read takes place on an rdClk edge only when rdEnN1 and rdEnN2 are both 0 and the buffer is not empty. Otherwise the output register keeps its previous word.
- R5: Write requests are ignored while fullN is 0.
- R6: Read requests are ignored while emptyN is 0, and the output register keeps the last word read.
- R7: With no reads after reset, fullN falls after exactly DEPTH writes.
- R8: almostFullN is 0 while the stored count is at least DEPTH-m. In programming mode m is fullOffset. In two-enable mode m is 7, whatever fullOffset holds.
- R9: almostEmptyN is 0 while the stored count is at most n. In programming mode n is emptyOffset. In two-enable mode n is 7. It rises once n+1 words are stored.
- R10: Words leave the buffer in the order in which they were accepted, without loss or duplication.
- R11: While outEnN is 1, rdDrive is 0 and rdData is 0. While outEnN is 0, rdDrive is 1 and rdData shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Active-low reset shared by both sides |
| wrEnN | input | 1 | Primary active-low write enable |
| wrEn2Ld | input | 1 | Second write enable or load marker; its level during reset selects the mode |
| wrData | input | DATA_W | Word to write |
| rdEnN1 | input | 1 | First active-low read enable |
| rdEnN2 | input | 1 | Second active-low read enable |
| outEnN | input | 1 | Active-low output enable |
| fullOffset | input | log2(DEPTH) | Almost-full distance from the offset block |
| emptyOffset | input | log2(DEPTH) | Almost-empty distance from the offset block |
| rdData | output | DATA_W | Output register contents when enabled, otherwise zero |
| rdDrive | output | 1 | High when rdData carries valid data |
| fullN | output | 1 | Active-low full flag, write-clock domain |
| almostFullN | output | 1 | Active-low almost-full flag, write-clock domain |
| emptyN | output | 1 | Active-low empty flag, read-clock domain |
| almostEmptyN | output | 1 | Active-low almost-empty flag, read-clock domain |

## Verification
The bench fills the buffer to the last word and goes past it, then drains it to zero and goes past that. These runs catch an off-by-one at either end: such an error would let a write overwrite unread data, or repeat a stale word when reading from empty. Each almost flag is checked on both sides of its threshold in both modes. Offset inputs that differ from 7 are applied in two-enable mode, so a design that forgot to force the default would move its thresholds. Dedicated tests cover:
- a load cycle and a half-enabled write, either of which a faulty design would store;
- a single read enable, on which a faulty design would advance the read pointer;
- the output enable, for which a faulty design would leak register contents while disabled.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // store wrData at the write address this wrClk edge
    logic rdEn;   // load the output register this rdClk edge
  } fifoStrobe_t;

  // Threshold distance used when offsets are not programmable
  localparam int DEFAULT_OFFSET = 7;

endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dOut   <= '0;
    end else begin
      stage1 <= dIn;
      dOut   <= stage1;
    end
  end

endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic          wrEn2Ld,
  input  logic          rdEnN1,
  input  logic          rdEnN2,
  input  logic [AW-1:0] fullOffset,
  input  logic [AW-1:0] emptyOffset,
  output fifoStrobe_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          progModeW,
  output logic          fullN,
  output logic          almostFullN,
  output logic          emptyN,
  output logic          almostEmptyN
);

  localparam logic [AW-1:0] DEF_OFF  = AW'(DEFAULT_OFFSET);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] rdGrayAtW, wrGrayAtR;
  logic [PW-1:0] wrLevel, rdLevel, afLimit;
  logic [AW-1:0] effFull, effEmpty;
  logic          progModeR;
  logic          isFull, isAlmostFull, isEmpty, isAlmostEmpty;

  // Mode capture: sampled on each clock edge while reset is held
  always_ff @(posedge wrClk) begin
    if (!rstN) progModeW <= ~wrEn2Ld;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) progModeR <= ~wrEn2Ld;
  end

  // Pointer crossing
  dcfifo_sync2 #(.WIDTH(PW)) syncRdToW_i (
    .clk (wrClk), .rstN(rstN), .dIn(rdGray), .dOut(rdGrayAtW)
  );

  dcfifo_sync2 #(.WIDTH(PW)) syncWrToR_i (
    .clk (rdClk), .rstN(rstN), .dIn(wrGray), .dOut(wrGrayAtR)
  );

  // Write side
  assign effFull      = progModeW ? fullOffset : DEF_OFF;
  assign wrLevel      = wrBin - fromGray(rdGrayAtW);
  assign afLimit      = FULL_LVL - {1'b0, effFull};
  assign isFull       = (wrLevel == FULL_LVL);
  assign isAlmostFull = (wrLevel >= afLimit);
  assign stb.wrEn     = ~wrEnN & wrEn2Ld & ~isFull;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (stb.wrEn) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  // Read side
  assign effEmpty      = progModeR ? emptyOffset : DEF_OFF;
  assign rdLevel       = fromGray(wrGrayAtR) - rdBin;
  assign isEmpty       = (rdLevel == '0);
  assign isAlmostEmpty = (rdLevel <= {1'b0, effEmpty});
  assign stb.rdEn      = ~rdEnN1 & ~rdEnN2 & ~isEmpty;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (stb.rdEn) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  assign wrAddr       = wrBin[AW-1:0];
  assign rdAddr       = rdBin[AW-1:0];
  assign fullN        = ~isFull;
  assign almostFullN  = ~isAlmostFull;
  assign emptyN       = ~isEmpty;
  assign almostEmptyN = ~isAlmostEmpty;

endmodule

// File: rtl/dcfifo_dpath.sv
module dcfifo_dpath
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  output logic [DATA_W-1:0] outReg,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         outReg <= '0;
    else if (stb.rdEn) outReg <= store[rdAddr];
  end

  assign rdDrive = ~outEnN;
  assign rdData  = outEnN ? '0 : outReg;

endmodule

// File: rtl/dcfifo_thresh.sv
module dcfifo_thresh
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              wrEn2Ld,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnN1,
  input  logic              rdEnN2,
  input  logic              outEnN,
  input  logic [AW-1:0]     fullOffset,
  input  logic [AW-1:0]     emptyOffset,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);

  fifoStrobe_t       stb;
  logic [AW-1:0]     wrAddr, rdAddr;
  logic [DATA_W-1:0] outReg;
  logic              progModeW;

  dcfifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .wrClk, .rdClk, .rstN, .wrEnN, .wrEn2Ld, .rdEnN1, .rdEnN2,
    .fullOffset, .emptyOffset, .stb, .wrAddr, .rdAddr, .progModeW,
    .fullN, .almostFullN, .emptyN, .almostEmptyN
  );

  dcfifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .wrClk, .rdClk, .rstN, .stb, .wrAddr, .rdAddr, .wrData, .outEnN,
    .outReg, .rdData, .rdDrive
  );

endmodule

// File: rtl/dcfifo_thresh_chk.sv
module dcfifo_thresh_chk #(
  parameter int DATA_W = 9
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEnN,
  input logic              wrEn2Ld,
  input logic              rdEnN1,
  input logic              rdEnN2,
  input logic              outEnN,
  input logic              wrStb,
  input logic              rdStb,
  input logic              progModeW,
  input logic [DATA_W-1:0] outReg,
  input logic              rdDrive,
  input logic              fullN,
  input logic              almostFullN,
  input logic              emptyN,
  input logic              almostEmptyN
);

  p_no_overflow_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !wrStb);

  p_no_underflow_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !rdStb);

  p_read_needs_both_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEnN1 || rdEnN2) |-> !rdStb);

  p_hold_when_idle_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdStb |=> $stable(outReg));

  p_write_needs_pin_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEnN || !wrEn2Ld) |-> !wrStb);

  p_mode_held_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    1'b1 |=> $stable(progModeW));

  p_full_implies_af_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN);

  p_empty_implies_ae_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);

  p_oe_release_r11: assert property (@(posedge rdClk) disable iff (!rstN)
    outEnN |-> !rdDrive);

endmodule

bind dcfifo_thresh dcfifo_thresh_chk #(.DATA_W(DATA_W)) chk_i (
  .wrClk        (wrClk),
  .rdClk        (rdClk),
  .rstN         (rstN),
  .wrEnN        (wrEnN),
  .wrEn2Ld      (wrEn2Ld),
  .rdEnN1       (rdEnN1),
  .rdEnN2       (rdEnN2),
  .outEnN       (outEnN),
  .wrStb        (stb.wrEn),
  .rdStb        (stb.rdEn),
  .progModeW    (progModeW),
  .outReg       (outReg),
  .rdDrive      (rdDrive),
  .fullN        (fullN),
  .almostFullN  (almostFullN),
  .emptyN       (emptyN),
  .almostEmptyN (almostEmptyN)
);

// File: tb/dcfifo_thresh_tb_top.sv
module dcfifo_thresh_tb_top;

  localparam int DW    = 9;
  localparam int DEPTH = 512;
  localparam int AW    = $clog2(DEPTH);
  localparam int STEPS = 11;

  // Table: writes, reads, expected {fullN, almostFullN, emptyN, almostEmptyN}
  localparam int stepWr [STEPS] = '{7, 1, 496, 1, 7, 3, 0, 0,   0, 0, 0};
  localparam int stepRd [STEPS] = '{0, 0, 0,   0, 0, 0, 1, 503, 1, 7, 2};
  localparam logic [3:0] stepFlags [STEPS] = '{
    4'b1110, 4'b1111, 4'b1111, 4'b1011, 4'b0011, 4'b0011,
    4'b1011, 4'b1111, 4'b1110, 4'b1100, 4'b1100};

  logic          wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic          wrEnN = 1'b1, wrEn2Ld = 1'b1, rdEnN1 = 1'b1, rdEnN2 = 1'b1;
  logic          outEnN = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] fullOffset = AW'(3), emptyOffset = AW'(2);
  logic [DW-1:0] rdData;
  logic          rdDrive, fullN, almostFullN, emptyN, almostEmptyN;

  int checks = 0, fails = 0, model = 0, wrSeq = 0, rdSeq = 0;
  logic [DW-1:0] lastExp = '0;
  bit done = 0;

  always #10 wrClk = ~wrClk;
  always #13.5 rdClk = ~rdClk;

  dcfifo_thresh #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .wrClk, .rdClk, .rstN, .wrEnN, .wrEn2Ld, .wrData, .rdEnN1, .rdEnN2,
    .outEnN, .fullOffset, .emptyOffset, .rdData, .rdDrive, .fullN,
    .almostFullN, .emptyN, .almostEmptyN
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag, input logic [3:0] exp);
    check(tag, int'({fullN, almostFullN, emptyN, almostEmptyN}), int'(exp));
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
    repeat (8) @(negedge wrClk);
  endtask

  task automatic applyReset(input logic modePin);
    @(negedge wrClk);
    rstN = 1'b0; wrEn2Ld = modePin; wrEnN = 1'b1;
    rdEnN1 = 1'b1; rdEnN2 = 1'b1;
    repeat (6) @(negedge rdClk);
    @(negedge wrClk);
    rstN = 1'b1; wrEn2Ld = 1'b1;
    model = 0; lastExp = '0;
    settle();
  endtask

  task automatic doWrites(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEnN = 1'b0; wrEn2Ld = 1'b1; wrData = DW'(wrSeq);
      if (model < DEPTH) begin
        model++;
        wrSeq++;
      end
    end
    @(negedge wrClk);
    wrEnN = 1'b1;
  endtask

  // R10: each read word compared with the next expected sequence value
  task automatic doReads(input int n);
    logic [DW-1:0] exp = lastExp;
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk);
      if (i > 0) check("R10 read order", int'(rdData), int'(exp));
      rdEnN1 = 1'b0; rdEnN2 = 1'b0;
      if (model > 0) begin
        exp = DW'(rdSeq);
        rdSeq++;
        model--;
      end
      lastExp = exp;
    end
    @(negedge rdClk);
    rdEnN1 = 1'b1; rdEnN2 = 1'b1;
    if (n > 0) check("R10 read order", int'(rdData), int'(exp));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state, two-enable mode selected by wrEn2Ld high
    applyReset(1'b1);
    checkFlags("R1 flags after reset", 4'b1100);
    check("R1 output register clear", int'(rdData), 0);
    check("R11 drive while enabled", int'(rdDrive), 1);

    // R2: second enable low blocks the write
    @(negedge wrClk);
    wrEnN = 1'b0; wrEn2Ld = 1'b0;
    repeat (4) @(negedge wrClk);
    wrEnN = 1'b1; wrEn2Ld = 1'b1;
    settle();
    check("R2 enable2 low stores nothing", int'(emptyN), 0);

    // Table walk; offset inputs 3/2 must be ignored in this mode (R8, R9)
    for (int s = 0; s < STEPS; s++) begin
      doWrites(stepWr[s]);
      doReads(stepRd[s]);
      settle();
      checkFlags($sformatf("R5 R6 R7 R8 R9 step %0d", s), stepFlags[s]);
    end
    check("R6 output held after empty read", int'(rdData), int'(lastExp));

    // R4: one read enable only
    doWrites(2);
    settle();
    @(negedge rdClk);
    rdEnN1 = 1'b0; rdEnN2 = 1'b1;
    repeat (4) @(negedge rdClk);
    rdEnN1 = 1'b1; rdEnN2 = 1'b0;
    repeat (4) @(negedge rdClk);
    rdEnN2 = 1'b1;
    check("R4 single enable holds register", int'(rdData), int'(lastExp));
    settle();
    check("R4 single enable leaves data", int'(emptyN), 1);
    doReads(2);
    settle();
    check("R4 drained", int'(emptyN), 0);

    // R11: output enable
    @(negedge rdClk);
    outEnN = 1'b1;
    @(negedge rdClk);
    check("R11 data zero when disabled", int'(rdData), 0);
    check("R11 drive low when disabled", int'(rdDrive), 0);
    outEnN = 1'b0;
    @(negedge rdClk);
    check("R11 data back when enabled", int'(rdData), int'(lastExp));

    // Programming mode: offsets full=3, empty=2
    applyReset(1'b0);
    checkFlags("R1 flags after second reset", 4'b1100);
    check("R1 register cleared again", int'(rdData), 0);
    @(negedge wrClk);
    wrEnN = 1'b0; wrEn2Ld = 1'b0;
    repeat (4) @(negedge wrClk);
    wrEnN = 1'b1; wrEn2Ld = 1'b1;
    settle();
    check("R3 load cycle stores nothing", int'(emptyN), 0);
    doWrites(2); settle();
    checkFlags("R9 count 2 at empty offset", 4'b1110);
    doWrites(1); settle();
    checkFlags("R9 count 3 above empty offset", 4'b1111);
    doWrites(505); settle();
    checkFlags("R8 count 508 below full offset", 4'b1111);
    doWrites(1); settle();
    checkFlags("R8 count 509 at full offset", 4'b1011);
    doWrites(3); settle();
    checkFlags("R7 full after DEPTH writes", 4'b0011);
    doReads(DEPTH); settle();
    checkFlags("R10 drained in order", 4'b1100);

    finishRun();
  end

endmodule